// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block settles the outcome of one conditional branch per transfer. Each item carries a 32-bit instruction word, the 32-bit condition register, the current count register, the return address to be linked and a register-held target. The block splits the instruction into a 4-bit option code, a static prediction hint, a 5-bit condition-bit selector, a link flag and a 14-bit word displacement. It then decides whether the branch is taken and computes the updated count register. It raises a link-register write request when linking is asked for, selects the target, and flags a misprediction against the hint.

Items enter on a valid/ready input stream and leave, one cycle after acceptance, on a valid/ready output stream that holds a single registered result. The input is ready whenever the result register is empty or is being drained in the same cycle. A result that the sink refuses stays on the output pins, unchanged, until the sink takes it. The source may stall freely. An item counts as accepted only on a clock edge where both `in_valid` and `in_ready` are high.

Top module: `br_resolve_unit`

## Requirements
- R1: Fields are taken from the instruction as follows: option code = bits 25..22, hint = bit 21, selector = bits 20..16, link flag = bit 0, displacement = bits 15..2. Selector value s tests condition register bit `in_cr[31-s]`, so the bit at in-field position p (0 less-than, 1 greater-than, 2 equal, 3 summary overflow) of field f (0..7) is `in_cr[31-(4f+p)]`.
- R2: Option codes 0010 and 0110 take the branch when the selected bit is 0 or 1 respectively, and they leave the count unchanged (`out_ctr_we` = 0, `out_ctr` = input count).
- R3: Option codes 0000, 0001, 0100 and 0101 decrement the count (`out_ctr_we` = 1, `out_ctr` = count-1). They take the branch only when the selected bit equals bit 2 of the code, and the new count is nonzero (code bit 0 = 0) or zero (code bit 0 = 1).
- R4: Option codes 1000 and 1001 decrement the count, wrapping modulo 2^32, and take the branch when the new count is nonzero or zero respectively. The condition bit is ignored.
- R5: Option code 1010 always takes the branch and leaves the count unchanged.
- R6: Every other option code sets `out_invalid`. The branch is not taken, `out_ctr_we` and `out_link_we` are 0, and `out_ctr` equals the input count.
- R7: `out_link_we` equals the link flag for valid codes, whatever the branch outcome, and `out_link_addr` carries the item's return address.
- R8: With `in_use_reg` = 0 the target is the displacement shifted left by two and sign extended from bit 15 to 32 bits. With `in_use_reg` = 1 it is `in_reg_target` with its two low bits cleared.
- R9: `out_mispredict` is 1 exactly when `out_taken` differs from the hint bit.
- R10: The result of an item accepted at a clock edge is on the outputs with `out_valid` = 1 after that edge. `in_ready` = !`out_valid` || `out_ready`. While `out_valid` && !`out_ready`, every output holds.
- R11: After reset `out_valid` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Unit can accept an item this cycle |
| in_instr | input | 32 | Branch instruction word |
| in_cr | input | 32 | Condition register |
| in_ctr | input | 32 | Current count register |
| in_ret_addr | input | 32 | Return address for the link write |
| in_reg_target | input | 32 | Register-held branch target |
| in_use_reg | input | 1 | Select register target instead of displacement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink accepts the result |
| out_taken | output | 1 | Branch taken |
| out_ctr | output | 32 | Updated count register |
| out_ctr_we | output | 1 | Count register write request |
| out_link_we | output | 1 | Link register write request |
| out_link_addr | output | 32 | Value for the link register |
| out_target | output | 32 | Selected target address |
| out_invalid | output | 1 | Option code outside the defined set |
| out_mispredict | output | 1 | Outcome differs from the hint |

## Verification
The assertions assume that the stream inputs carry known values whenever `in_valid` is high after reset. They also assume that the sink may hold `out_ready` low for any number of cycles. Stimulus changes inputs only half a period away from the active edge, and it keeps each item on the input until the unit accepts it. It drives a varying `out_ready` pattern so that stalls, back-to-back transfers and idle cycles all occur. Count values cluster around 0, 1 and 2 so that the wrap and zero-test corners come up often.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int unsigned BR_XLEN   = 32;
  localparam int unsigned BR_CR_W   = 32;
  localparam int unsigned BR_DISP_W = 14;
  localparam int unsigned BR_SEL_W  = $clog2(BR_CR_W);

  // option codes that have a defined meaning
  localparam logic [3:0] OPT_DNZ_F  = 4'b0000;
  localparam logic [3:0] OPT_DZ_F   = 4'b0001;
  localparam logic [3:0] OPT_F      = 4'b0010;
  localparam logic [3:0] OPT_DNZ_T  = 4'b0100;
  localparam logic [3:0] OPT_DZ_T   = 4'b0101;
  localparam logic [3:0] OPT_T      = 4'b0110;
  localparam logic [3:0] OPT_DNZ    = 4'b1000;
  localparam logic [3:0] OPT_DZ     = 4'b1001;
  localparam logic [3:0] OPT_ALWAYS = 4'b1010;

  typedef enum logic [1:0] {
    CLS_COND_CNT,
    CLS_COND,
    CLS_CNT,
    CLS_NONE
  } br_class_e;
endpackage

// File: rtl/br_field_split.sv
module br_field_split
  import br_pkg::*;
#(
  parameter int unsigned SEL_W  = BR_SEL_W,
  parameter int unsigned DISP_W = BR_DISP_W
) (
  input  logic [31:0]       instr,
  output logic [3:0]        opt,
  output logic              hint,
  output logic [SEL_W-1:0]  sel,
  output logic              link,
  output logic [DISP_W-1:0] disp
);
  // primary opcode and absolute-address bit are outside this unit's scope
  logic unused_bits;
  assign unused_bits = ^{instr[31:26], instr[1]};

  assign opt  = instr[25:22];
  assign hint = instr[21];
  assign sel  = instr[16 +: SEL_W];
  assign link = instr[0];
  assign disp = instr[2 +: DISP_W];
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int unsigned XLEN  = BR_XLEN,
  parameter int unsigned CR_W  = BR_CR_W,
  localparam int unsigned SEL_W = $clog2(CR_W)
) (
  input  logic [3:0]       opt,
  input  logic [SEL_W-1:0] sel,
  input  logic [CR_W-1:0]  cr,
  input  logic [XLEN-1:0]  ctr,
  output logic             taken,
  output logic [XLEN-1:0]  ctr_next,
  output logic             ctr_we,
  output logic             invalid
);
  // selector 0 addresses the most significant condition bit
  logic [CR_W-1:0] cr_msb0;
  for (genvar g = 0; g < CR_W; g++) begin : g_cr_rev
    assign cr_msb0[g] = cr[CR_W-1-g];
  end

  logic            cond_bit;
  logic [XLEN-1:0] ctr_dec;
  logic            cond_ok;
  logic            cnt_ok;
  br_class_e       cls;

  assign cond_bit = cr_msb0[sel];
  assign ctr_dec  = ctr - XLEN'(1);
  assign cond_ok  = (cond_bit == opt[2]);
  assign cnt_ok   = ((ctr_dec == '0) == opt[0]);

  always_comb begin
    cls     = CLS_NONE;
    invalid = 1'b0;
    taken   = 1'b0;
    case (opt)
      OPT_DNZ_F, OPT_DZ_F, OPT_DNZ_T, OPT_DZ_T: cls = CLS_COND_CNT;
      OPT_F, OPT_T:                             cls = CLS_COND;
      OPT_DNZ, OPT_DZ:                          cls = CLS_CNT;
      OPT_ALWAYS:                               cls = CLS_NONE;
      default:                                  invalid = 1'b1;
    endcase
    if (!invalid) begin
      case (cls)
        CLS_COND_CNT: taken = cond_ok && cnt_ok;
        CLS_COND:     taken = cond_ok;
        CLS_CNT:      taken = cnt_ok;
        default:      taken = 1'b1;
      endcase
    end
    ctr_we   = !invalid && (cls == CLS_COND_CNT || cls == CLS_CNT);
    ctr_next = ctr_we ? ctr_dec : ctr;
  end
endmodule

// File: rtl/br_target_sel.sv
module br_target_sel
  import br_pkg::*;
#(
  parameter int unsigned XLEN   = BR_XLEN,
  parameter int unsigned DISP_W = BR_DISP_W,
  localparam int unsigned EXT_W = XLEN - DISP_W - 2
) (
  input  logic [DISP_W-1:0] disp,
  input  logic              use_reg,
  input  logic [XLEN-1:0]   reg_target,
  output logic [XLEN-1:0]   target
);
  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] reg_aligned;

  assign disp_ext    = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
  assign reg_aligned = {reg_target[XLEN-1:2], 2'b00};
  assign target      = use_reg ? reg_aligned : disp_ext;
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
  import br_pkg::*;
#(
  parameter int unsigned XLEN   = BR_XLEN,
  parameter int unsigned CR_W   = BR_CR_W,
  parameter int unsigned DISP_W = BR_DISP_W,
  localparam int unsigned SEL_W = $clog2(CR_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  input  logic [CR_W-1:0] in_cr,
  input  logic [XLEN-1:0] in_ctr,
  input  logic [XLEN-1:0] in_ret_addr,
  input  logic [XLEN-1:0] in_reg_target,
  input  logic            in_use_reg,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_taken,
  output logic [XLEN-1:0] out_ctr,
  output logic            out_ctr_we,
  output logic            out_link_we,
  output logic [XLEN-1:0] out_link_addr,
  output logic [XLEN-1:0] out_target,
  output logic            out_invalid,
  output logic            out_mispredict
);
  logic [3:0]        f_opt;
  logic              f_hint;
  logic [SEL_W-1:0]  f_sel;
  logic              f_link;
  logic [DISP_W-1:0] f_disp;

  br_field_split #(.SEL_W(SEL_W), .DISP_W(DISP_W)) u_split (
    .instr (in_instr),
    .opt   (f_opt),
    .hint  (f_hint),
    .sel   (f_sel),
    .link  (f_link),
    .disp  (f_disp)
  );

  logic            e_taken;
  logic [XLEN-1:0] e_ctr;
  logic            e_ctr_we;
  logic            e_invalid;

  br_cond_eval #(.XLEN(XLEN), .CR_W(CR_W)) u_eval (
    .opt      (f_opt),
    .sel      (f_sel),
    .cr       (in_cr),
    .ctr      (in_ctr),
    .taken    (e_taken),
    .ctr_next (e_ctr),
    .ctr_we   (e_ctr_we),
    .invalid  (e_invalid)
  );

  logic [XLEN-1:0] t_target;

  br_target_sel #(.XLEN(XLEN), .DISP_W(DISP_W)) u_tgt (
    .disp       (f_disp),
    .use_reg    (in_use_reg),
    .reg_target (in_reg_target),
    .target     (t_target)
  );

  logic fire;
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_taken      <= 1'b0;
      out_ctr        <= '0;
      out_ctr_we     <= 1'b0;
      out_link_we    <= 1'b0;
      out_link_addr  <= '0;
      out_target     <= '0;
      out_invalid    <= 1'b0;
      out_mispredict <= 1'b0;
    end else if (fire) begin
      out_taken      <= e_taken;
      out_ctr        <= e_ctr;
      out_ctr_we     <= e_ctr_we;
      out_link_we    <= f_link && !e_invalid;
      out_link_addr  <= in_ret_addr;
      out_target     <= t_target;
      out_invalid    <= e_invalid;
      out_mispredict <= e_taken ^ f_hint;
    end
  end

  // count result relative to the accepted count
  assert_ctr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (out_ctr == ($past(in_ctr) - XLEN'(out_ctr_we))));

  // count-only code with wrap
  assert_cnt_only_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_instr[25:23] == 3'b100) |=> (out_ctr_we && out_ctr == $past(in_ctr) - XLEN'(1)));

  assert_always_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_instr[25:22] == OPT_ALWAYS) |=> (out_taken && !out_ctr_we));

  assert_invalid_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (!out_taken && !out_ctr_we && !out_link_we));

  assert_link_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (out_link_addr == $past(in_ret_addr)));

  assert_mispredict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (out_mispredict == (out_taken ^ $past(in_instr[21]))));

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_taken) && $stable(out_ctr)
      && $stable(out_target) && $stable(out_link_addr) && $stable(out_invalid)));

  assert_result_follows_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_empty_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

// File: tb/test_br_resolve_unit.sv
module test_br_resolve_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] in_cr = '0;
  logic [31:0] in_ctr = '0;
  logic [31:0] in_ret_addr = '0;
  logic [31:0] in_reg_target = '0;
  logic        in_use_reg = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_taken;
  logic [31:0] out_ctr;
  logic        out_ctr_we;
  logic        out_link_we;
  logic [31:0] out_link_addr;
  logic [31:0] out_target;
  logic        out_invalid;
  logic        out_mispredict;

  always #2.5 clk = ~clk;

  br_resolve_unit i_br_resolve_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_cr(in_cr), .in_ctr(in_ctr),
    .in_ret_addr(in_ret_addr), .in_reg_target(in_reg_target), .in_use_reg(in_use_reg),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_ctr(out_ctr), .out_ctr_we(out_ctr_we),
    .out_link_we(out_link_we), .out_link_addr(out_link_addr), .out_target(out_target),
    .out_invalid(out_invalid), .out_mispredict(out_mispredict)
  );

  typedef struct packed {
    logic        taken;
    logic [31:0] ctr;
    logic        ctr_we;
    logic        link_we;
    logic [31:0] link;
    logic [31:0] tgt;
    logic        invalid;
    logic        mis;
    logic [3:0]  opt;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit monitor_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'b0010, 4'b0110:                   return "R2 taken";
      4'b0000, 4'b0001, 4'b0100, 4'b0101: return "R3 taken";
      4'b1000, 4'b1001:                   return "R4 taken";
      4'b1010:                            return "R5 taken";
      default:                            return "R6 taken";
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] o, input logic h, input logic [4:0] s,
                                     input logic lk, input logic [13:0] d);
    return {6'b010000, o, h, s, d, 1'b0, lk};
  endfunction

  // expected result from the requirements
  function automatic exp_t model(input logic [31:0] ins, input logic [31:0] cr, input logic [31:0] ctr,
                                 input logic [31:0] ret, input logic [31:0] rt, input logic ur);
    exp_t e;
    logic [3:0] o;
    logic c;
    logic [31:0] nc;
    bit bad;
    bit dec;
    bit tk;
    o   = ins[25:22];
    c   = cr[31 - ins[20:16]];
    nc  = ctr - 32'd1;
    bad = 1'b0;
    dec = 1'b0;
    tk  = 1'b0;
    case (o)
      4'b0000: begin dec = 1; tk = (c == 1'b0) && (nc != 0); end
      4'b0001: begin dec = 1; tk = (c == 1'b0) && (nc == 0); end
      4'b0100: begin dec = 1; tk = (c == 1'b1) && (nc != 0); end
      4'b0101: begin dec = 1; tk = (c == 1'b1) && (nc == 0); end
      4'b0010: tk = (c == 1'b0);
      4'b0110: tk = (c == 1'b1);
      4'b1000: begin dec = 1; tk = (nc != 0); end
      4'b1001: begin dec = 1; tk = (nc == 0); end
      4'b1010: tk = 1'b1;
      default: bad = 1'b1;
    endcase
    e.taken   = tk;
    e.ctr_we  = dec;
    e.ctr     = dec ? nc : ctr;
    e.link_we = ins[0] && !bad;
    e.link    = ret;
    e.tgt     = ur ? {rt[31:2], 2'b00} : {{16{ins[15]}}, ins[15:2], 2'b00};
    e.invalid = bad;
    e.mis     = tk ^ ins[21];
    e.opt     = o;
    return e;
  endfunction

  task automatic send(input logic [31:0] ins, input logic [31:0] cr, input logic [31:0] ctr,
                      input logic [31:0] ret, input logic [31:0] rt, input logic ur);
    @(negedge clk);
    in_valid = 1'b1; in_instr = ins; in_cr = cr; in_ctr = ctr;
    in_ret_addr = ret; in_reg_target = rt; in_use_reg = ur;
    forever begin
      #1;
      if (in_ready) begin
        q.push_back(model(ins, cr, ctr, ret, rt, ur));
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: drive ready, compare transfers, check stall hold
  logic        stalled = 1'b0;
  logic [31:0] s_ctr;
  logic [31:0] s_tgt;
  logic        s_taken;
  initial begin
    exp_t e;
    wait (monitor_on);
    forever begin
      @(negedge clk);
      out_ready = (($urandom % 4) != 0);
      #1;
      if (stalled && out_valid) begin
        chk(out_ctr == s_ctr && out_tgt_ok(s_tgt) && out_taken == s_taken, "R10 hold", out_ctr, s_ctr);
      end
      stalled = out_valid && !out_ready;
      s_ctr = out_ctr; s_tgt = out_target; s_taken = out_taken;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected result", 32'd1, 32'd0);
        end else begin
          e = q.pop_front();
          chk(out_taken == e.taken, tag_of(e.opt), {31'd0, out_taken}, {31'd0, e.taken});
          chk(out_ctr == e.ctr, "R3 R4 count value", out_ctr, e.ctr);
          chk(out_ctr_we == e.ctr_we, "R2 count write", {31'd0, out_ctr_we}, {31'd0, e.ctr_we});
          chk(out_link_we == e.link_we, "R7 link write", {31'd0, out_link_we}, {31'd0, e.link_we});
          chk(out_link_addr == e.link, "R7 link addr", out_link_addr, e.link);
          chk(out_target == e.tgt, "R8 target", out_target, e.tgt);
          chk(out_invalid == e.invalid, "R6 invalid", {31'd0, out_invalid}, {31'd0, e.invalid});
          chk(out_mispredict == e.mis, "R9 mispredict", {31'd0, out_mispredict}, {31'd0, e.mis});
        end
      end
    end
  end

  function automatic bit out_tgt_ok(input logic [31:0] t);
    return out_target == t;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", q.size());
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(out_valid == 1'b0, "R11 out_valid", {31'd0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R11 in_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    monitor_on = 1'b1;

    // R1: each bit position of several fields, conditional-only codes (R2)
    for (int f = 0; f < 8; f += 3) begin
      for (int p = 0; p < 4; p++) begin
        send(mk(4'b0110, 1'b0, 5'(4*f+p), 1'b0, 14'h0010), 32'h1 << (31 - (4*f+p)), 32'd5, 32'h100, 32'h0, 1'b0);
        send(mk(4'b0010, 1'b1, 5'(4*f+p), 1'b1, 14'h3ff0), 32'h1 << (31 - (4*f+p)), 32'd5, 32'h104, 32'h0, 1'b0);
      end
    end
    // R3 decrement with condition
    send(mk(4'b0000, 1'b0, 5'd2, 1'b0, 14'h1), 32'h0, 32'd2, 32'h10, 32'h0, 1'b0);
    send(mk(4'b0001, 1'b1, 5'd2, 1'b1, 14'h1), 32'h0, 32'd1, 32'h14, 32'h0, 1'b0);
    send(mk(4'b0100, 1'b0, 5'd0, 1'b0, 14'h1), 32'h8000_0000, 32'd1, 32'h18, 32'h0, 1'b0);
    send(mk(4'b0101, 1'b1, 5'd0, 1'b0, 14'h1), 32'h8000_0000, 32'd1, 32'h1c, 32'h0, 1'b0);
    // R4 wrap from zero
    send(mk(4'b1000, 1'b1, 5'd7, 1'b0, 14'h2), 32'h0, 32'd0, 32'h20, 32'h0, 1'b0);
    send(mk(4'b1001, 1'b0, 5'd7, 1'b0, 14'h2), 32'hffff_ffff, 32'd0, 32'h24, 32'h0, 1'b0);
    send(mk(4'b1001, 1'b0, 5'd7, 1'b1, 14'h2), 32'h0, 32'd1, 32'h28, 32'h0, 1'b0);
    // R5 always, register target (R8)
    send(mk(4'b1010, 1'b0, 5'd9, 1'b1, 14'h2), 32'h0, 32'd0, 32'h2c, 32'hdead_beef, 1'b1);
    // R6 invalid codes with link flag set
    send(mk(4'b0011, 1'b1, 5'd0, 1'b1, 14'h0), 32'hffff_ffff, 32'd3, 32'h30, 32'h0, 1'b0);
    send(mk(4'b1111, 1'b0, 5'd0, 1'b1, 14'h0), 32'hffff_ffff, 32'd0, 32'h34, 32'h0, 1'b0);
    send(mk(4'b1011, 1'b0, 5'd0, 1'b1, 14'h0), 32'h0, 32'd1, 32'h38, 32'h0, 1'b0);
    // mixed random stream
    for (int i = 0; i < 400; i++) begin
      logic [31:0] c;
      case ($urandom % 4)
        0: c = 32'd0;
        1: c = 32'd1;
        2: c = 32'd2;
        default: c = $urandom;
      endcase
      send(mk(4'($urandom), 1'($urandom), 5'($urandom), 1'($urandom), 14'($urandom)),
           $urandom, c, $urandom, $urandom, 1'($urandom));
    end
    repeat (20) @(posedge clk);
    chk(q.size() == 0, "R10 all results delivered", q.size(), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule